// File: doc/BRIEF.md
# Graphic LCD Bus Write Snooper

This block listens, without driving anything, to the parallel host bus of a two-controller graphic LCD. It picks out every cycle in which the host writes display data or a command. For each such cycle it keeps the 8 data lines and the four control lines: direction, data/command select, and the two controller selects. All five bus inputs and the strobe pass through two-flop synchronisers into the system clock. The block samples them on the falling edge of the strobe, because that is the last moment they are guaranteed to be valid. The 12-bit word is kept from the register stage behind the one that first shows the strobe low, so it holds the bus as it stood while the strobe was still high.

A captured word goes into a single holding register and raises a pending flag, which serves as the interrupt request. A reader collects the word through an SPI-style shift port (mode 0, most significant bit first). A rising edge on the load input copies the held word into the shift register and clears the pending flag in the same action. After that, the holding register is free again, so the host can complete another write while the previous frame is still being clocked out. If the host writes again while a word is still pending, the newer word replaces it and a sticky overrun bit is set. The overrun bit is reported in the next frame.

Top module: `lcd_write_snoop`

## Requirements
- R1: After reset `evt_pending` is 0 and `rd_miso` is 0.
- R2: A bus cycle with `bus_dir` = 0 (write) sets `evt_pending` to 1 within four clock edges after the synchroniser sees `bus_strobe` fall. The strobe must be high for at least 4 clocks and low for at least 4 clocks.
- R3: A bus cycle with `bus_dir` = 1 (read or status read) changes neither `evt_pending` nor the held word. A later load returns the previous write again.
- R4: The captured word is the bus state at the last clock before the strobe falls. Data changes made one clock after the strobe falls do not appear in the frame.
- R5: The frame is 16 bits, sent MSB first. Bit 15 is overrun, bits 14..12 are 0, bit 11 is direction, bit 10 is data/command select, bit 9 is select A, bit 8 is select B, and bits 7..0 are data.
- R6: A rising edge on `rd_load` clears `evt_pending` and puts frame bit 15 on `rd_miso`. Each falling edge of `rd_sclk` moves the next bit onto `rd_miso`, so the reader samples on rising `rd_sclk`.
- R7: A write captured while a frame is being shifted out does not change that frame. It sets `evt_pending`, and the next load returns the new word.
- R8: A write captured while `evt_pending` is already 1 replaces the held word and sets overrun. The next frame carries bit 15 = 1, and the load clears overrun so the frame after it carries 0.
- R9: Write cycles that start 100 clocks (1 µs) apart are each captured when a load and shift-out of the previous word happen in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_strobe | input | 1 | LCD bus enable strobe (asynchronous) |
| bus_dir | input | 1 | LCD bus direction, 0 = write, 1 = read |
| bus_dc | input | 1 | LCD data/command select |
| bus_sel_a | input | 1 | Controller A select |
| bus_sel_b | input | 1 | Controller B select |
| bus_d | input | DW | LCD data lines |
| rd_load | input | 1 | Reader load strobe; rising edge transfers held word and clears pending |
| rd_sclk | input | 1 | Reader serial clock, mode 0 |
| rd_miso | output | 1 | Serial frame output |
| evt_pending | output | 1 | Word waiting; interrupt request |

## Verification
The hardest case to reach is a new write captured in the middle of a shift-out. The bench clocks out half a frame and runs a complete write cycle while `rd_sclk` is idle. It then shifts the rest of the frame and reads the following one, so any corruption or any lost word shows up in the frames. Overrun needs two writes with no load between them, and its clearing is proven by a third frame. Read cycles are proven harmless by loading the same held word again after one.

// File: rtl/lcd_write_snoop.sv
module lcd_write_snoop #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_strobe,
  input  logic          bus_dir,
  input  logic          bus_dc,
  input  logic          bus_sel_a,
  input  logic          bus_sel_b,
  input  logic [DW-1:0] bus_d,
  input  logic          rd_load,
  input  logic          rd_sclk,
  output logic          rd_miso,
  output logic          evt_pending
);
  localparam int WW    = DW + 4;
  localparam int BW    = WW + 1;
  localparam int FRAME = DW + 8;
  localparam int PAD   = FRAME - WW - 1;

  logic [BW-1:0]    s1, s2, s3;
  logic [2:0]       lk, ck;
  logic [WW-1:0]    hold;
  logic [FRAME-1:0] shreg;
  logic             ovr;

  wire [BW-1:0] bus_v   = {bus_strobe, bus_dir, bus_dc, bus_sel_a, bus_sel_b, bus_d};
  wire          fall    = s3[BW-1] & ~s2[BW-1];
  wire          cap     = fall & ~s3[WW-1];
  wire          load_p  = lk[1] & ~lk[2];
  wire          shift_p = ck[2] & ~ck[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      s3 <= '0;
      lk <= '0;
      ck <= '0;
    end else begin
      s1 <= bus_v;
      s2 <= s1;
      s3 <= s2;
      lk <= {lk[1:0], rd_load};
      ck <= {ck[1:0], rd_sclk};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold        <= '0;
      evt_pending <= 1'b0;
      ovr         <= 1'b0;
    end else begin
      if (cap) hold <= s3[WW-1:0];
      evt_pending <= cap | (evt_pending & ~load_p);
      ovr         <= load_p ? 1'b0 : (ovr | (cap & evt_pending));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shreg <= '0;
    else if (load_p)  shreg <= {ovr, {PAD{1'b0}}, hold};
    else if (shift_p) shreg <= {shreg[FRAME-2:0], 1'b0};
  end

  assign rd_miso = shreg[FRAME-1];
endmodule

// File: rtl/lcd_write_snoop_chk.sv
module lcd_write_snoop_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap,
  input logic          fall,
  input logic          load_p,
  input logic          shift_p,
  input logic          evt_pending,
  input logic          ovr,
  input logic [DW+3:0] hold,
  input logic [DW+7:0] shreg
);
  p_capture_sets_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> evt_pending);

  p_read_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !cap && !load_p) |=> ($stable(evt_pending) && $stable(hold)));

  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_p |=> (shreg[DW+6:DW+4] == 3'b000));

  p_load_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_p && !cap) |=> !evt_pending);

  p_frame_intact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_p && !shift_p) |=> $stable(shreg));

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && evt_pending && !load_p) |=> ovr);

  p_overrun_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_p |=> !ovr);
endmodule

bind lcd_write_snoop lcd_write_snoop_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cap(cap), .fall(fall), .load_p(load_p),
  .shift_p(shift_p), .evt_pending(evt_pending), .ovr(ovr), .hold(hold),
  .shreg(shreg)
);

// File: tb/sim_lcd_write_snoop.sv
`timescale 1ns/1ps
module sim_lcd_write_snoop;
  logic clk = 0, rst_n = 0;
  logic bus_strobe = 0, bus_dir = 0, bus_dc = 0, bus_sel_a = 0, bus_sel_b = 0;
  logic [7:0] bus_d = 0;
  logic rd_load = 0, rd_sclk = 0;
  logic rd_miso, evt_pending;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  lcd_write_snoop #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_strobe(bus_strobe), .bus_dir(bus_dir),
    .bus_dc(bus_dc), .bus_sel_a(bus_sel_a), .bus_sel_b(bus_sel_b), .bus_d(bus_d),
    .rd_load(rd_load), .rd_sclk(rd_sclk), .rd_miso(rd_miso), .evt_pending(evt_pending)
  );

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_cycle(input logic dir, input logic [3:0] ctl, input logic [7:0] d, input int hi);
    bus_dir = dir; bus_dc = ctl[2]; bus_sel_a = ctl[1]; bus_sel_b = ctl[0]; bus_d = d;
    wait_n(3);
    bus_strobe = 1;
    wait_n(hi);
    bus_strobe = 0;
    wait_n(1);
    bus_d = ~d; bus_dc = ~ctl[2];
    wait_n(100 - hi - 4);
  endtask

  task automatic do_load();
    rd_load = 1; wait_n(6); rd_load = 0; wait_n(2);
  endtask

  task automatic shift_bits(input int n, inout logic [15:0] f);
    for (int i = 0; i < n; i++) begin
      f = {f[14:0], rd_miso};
      rd_sclk = 1; wait_n(4);
      rd_sclk = 0; wait_n(5);
    end
  endtask

  task automatic read_frame(output logic [15:0] f);
    logic [15:0] t = 0;
    do_load();
    shift_bits(16, t);
    f = t;
  endtask

  function automatic logic [15:0] word(input logic ov, input logic dir, input logic [3:0] ctl, input logic [7:0] d);
    return {ov, 3'b000, dir, ctl[2], ctl[1], ctl[0], d};
  endfunction

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] f, g;
    wait_n(3);
    chk("R1 pending", {15'd0, evt_pending}, 16'd0);
    chk("R1 miso", {15'd0, rd_miso}, 16'd0);
    rst_n = 1;
    wait_n(3);

    for (int i = 0; i < 16; i++) begin
      logic [7:0] d = 8'(i * 37 + 5);
      logic [3:0] c = {1'b0, 3'(i)};
      bus_cycle(0, c, d, 20);
      chk("R2 pending after write", {15'd0, evt_pending}, 16'd1);
      read_frame(f);
      chk("R5/R4 frame content", f, word(0, 0, c, d));
      chk("R6 pending cleared by load", {15'd0, evt_pending}, 16'd0);
    end

    bus_cycle(0, 4'b0101, 8'hA5, 20);
    read_frame(f);
    chk("R3 reference write", f, word(0, 0, 4'b0101, 8'hA5));
    bus_cycle(1, 4'b0011, 8'h3C, 20);
    chk("R3 read leaves pending low", {15'd0, evt_pending}, 16'd0);
    read_frame(f);
    chk("R3 held word unchanged by read", f, word(0, 0, 4'b0101, 8'hA5));

    bus_cycle(0, 4'b0110, 8'h81, 20);
    f = 0;
    do_load();
    shift_bits(8, f);
    bus_cycle(0, 4'b0001, 8'h7E, 20);
    chk("R7 pending during shift", {15'd0, evt_pending}, 16'd1);
    shift_bits(8, f);
    chk("R7 frame not corrupted", f, word(0, 0, 4'b0110, 8'h81));
    read_frame(g);
    chk("R7 second word", g, word(0, 0, 4'b0001, 8'h7E));

    bus_cycle(0, 4'b0010, 8'h11, 20);
    bus_cycle(0, 4'b0100, 8'h22, 20);
    read_frame(f);
    chk("R8 overrun flagged newest kept", f, word(1, 0, 4'b0100, 8'h22));
    bus_cycle(0, 4'b0111, 8'h33, 20);
    read_frame(f);
    chk("R8 overrun cleared", f, word(0, 0, 4'b0111, 8'h33));

    bus_cycle(0, 4'b0011, 8'hC3, 4);
    chk("R9 short strobe captured", {15'd0, evt_pending}, 16'd1);
    f = 0;
    do_load();
    wait_n(100 - 8);
    bus_cycle(0, 4'b0100, 8'h5A, 4);
    shift_bits(16, f);
    chk("R9 first of pair", f, word(0, 0, 4'b0011, 8'hC3));
    read_frame(g);
    chk("R9 second of pair", g, word(0, 0, 4'b0100, 8'h5A));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule